// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Serial Grant Chain

This block decides which device may interrupt a small 16-bit processor and then fetches the handler entry for it. Up to eight device slots each hold a pending flag, a two-bit level and a vector index. The pending slots drive four level request lines. A request line can also be driven by a stray source that belongs to no slot. When the processor's current priority allows it, the controller picks the highest request line and drives the grant for that one level. The grant passes through the slots in index order. The first pending slot at that level keeps the grant and stops it from going further.

The winning slot supplies its vector index. The controller turns the index into a byte address that is a multiple of four. Over a simple ready-handshaked read port it then reads two words: the handler program counter at the address itself, and the new status word two bytes above it. It presents both words to the core for one cycle. While the fetch is under way it tells the core that the old state has to be saved. A grant that no slot takes ends after a fixed timeout with a spurious-interrupt pulse and no memory traffic.

A slot stays pending until its own clear input is pulsed, which models software rearming the device. A request that is refused or loses arbitration is therefore offered again in a later round.

Top module: `irq_chain_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, grant_lines, mem_rd, irq_take, push_req and spurious are all 0.
- R2: At most one grant line is high at a time. When several request lines are eligible, the one with the highest level wins. Line k stands for priority 4+k.
- R3: A request line k is granted only if 4+k is strictly greater than cur_pri. With cur_pri at or above 4+k, that line receives no grant.
- R4: Among slots pending at the granted level, the slot with the lowest index takes the grant. Slots further along are served in later rounds.
- R5: The vector address is the winner's dev_vid value times four. The program counter is read at that address and the status word at that address plus two. mem_rd and mem_addr stay stable until mem_ready is seen high.
- R6: After the second read, irq_take pulses for one cycle. During that pulse new_pc carries the first word read and new_psw carries the second. The core takes its new priority from new_psw bits 7:5.
- R7: A slot raised by dev_raise stays pending until dev_clr. A request that is blocked or loses arbitration is served later without being raised again.
- R8: If no slot takes a grant, the grant stays high for exactly 16 cycles. spurious then pulses for one cycle, with no memory read and no irq_take.
- R9: push_req is high from the cycle after a slot takes the grant through the irq_take cycle, and low otherwise.
- R10: When dev_clr and dev_raise reach the same slot in the same cycle, the clear wins and the slot is not pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_raise | input | NSLOT | Per-slot pulse that makes the slot pending |
| dev_clr | input | NSLOT | Per-slot pulse that releases the slot's request |
| dev_level | input | 2*NSLOT | Level of each slot; value k means priority 4+k |
| dev_vid | input | VID_W*NSLOT | Vector index of each slot |
| stray_req | input | 4 | Request per level from no slot |
| cur_pri | input | 3 | Priority field of the current status word |
| grant_lines | output | 4 | Grant for each level, at most one high |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read byte address |
| mem_ready | input | 1 | Read data valid, completes the read |
| mem_rdata | input | 16 | Read data |
| irq_take | output | 1 | One-cycle pulse: handler words valid |
| new_pc | output | 16 | Handler program counter |
| new_psw | output | 16 | New status word |
| push_req | output | 1 | Core must save its state |
| spurious | output | 1 | One-cycle pulse: unanswered grant |

## Verification
The hardest situation to reach is a grant that no slot answers. Every pending slot drives its own level line, so its grant is always taken. The stimulus drives a stray request on one line while no slot is pending at that level. The bench then counts the grant cycles and expects the spurious pulse with no read. Chain order and the recovery of blocked requests are reached by raising two slots in the same cycle. The bench then holds cur_pri at the status-word priority until each served slot is cleared and the saved priority is put back.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NLVL     = 4;
    localparam int LVL_W    = 2;
    localparam int LVL_BASE = 4;
    localparam int PRI_W    = 3;
    localparam int AW       = 16;
    localparam int DW       = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GRANT,
        S_RD_PC,
        S_RD_PSW,
        S_DELIVER,
        S_SPUR
    } seq_state_e;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] idx;
    } lvl_pick_t;

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] psw;
    } handler_t;

    // highest request line whose priority beats the current one
    function automatic lvl_pick_t pick_level(input logic [NLVL-1:0] req,
                                             input logic [PRI_W-1:0] pri);
        lvl_pick_t r;
        r = '0;
        for (int j = 0; j < NLVL; j++) begin
            if (req[j] && (PRI_W'(LVL_BASE + j) > pri)) begin
                r.hit = 1'b1;
                r.idx = LVL_W'(j);
            end
        end
        return r;
    endfunction

    function automatic logic [LVL_W-1:0] grant_index(input logic [NLVL-1:0] g);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int j = 0; j < NLVL; j++) begin
            if (g[j]) r = LVL_W'(j);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_pkg::*;
(
    input  logic [NLVL-1:0]  req_lines,
    input  logic [PRI_W-1:0] cur_pri,
    output logic             hit,
    output logic [LVL_W-1:0] idx
);
    lvl_pick_t pick;

    always_comb begin
        pick = pick_level(req_lines, cur_pri);
        hit  = pick.hit;
        idx  = pick.idx;
    end

endmodule

// File: rtl/irq_slot_chain.sv
module irq_slot_chain
    import irq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int VID_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSLOT-1:0]       raise,
    input  logic [NSLOT-1:0]       clr,
    input  logic [LVL_W*NSLOT-1:0] slot_lvl,
    input  logic [VID_W*NSLOT-1:0] slot_vid,
    input  logic [NLVL-1:0]        stray,
    input  logic [NLVL-1:0]        grant,
    output logic [NLVL-1:0]        req_lines,
    output logic                   ack,
    output logic [VID_W-1:0]       ack_vid
);
    logic [NSLOT-1:0] pend_q;
    logic [NSLOT-1:0] take;

    // pending flags: clear has precedence over raise
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLOT; s++) begin
            if (rst || clr[s])  pend_q[s] <= 1'b0;
            else if (raise[s])  pend_q[s] <= 1'b1;
        end
    end

    // one serial grant path per level; first pending slot absorbs it
    always_comb begin
        logic pass;
        take = '0;
        for (int lv = 0; lv < NLVL; lv++) begin
            pass = grant[lv];
            for (int s = 0; s < NSLOT; s++) begin
                if (pass && pend_q[s] &&
                    (slot_lvl[LVL_W*s +: LVL_W] == LVL_W'(lv))) begin
                    take[s] = 1'b1;
                    pass    = 1'b0;
                end
            end
        end
    end

    always_comb begin
        ack     = |take;
        ack_vid = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (take[s]) ack_vid = ack_vid | slot_vid[VID_W*s +: VID_W];
        end
    end

    for (genvar lv = 0; lv < NLVL; lv++) begin : g_line
        logic [NSLOT-1:0] at_lvl;
        for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
            assign at_lvl[s] = pend_q[s] &&
                               (slot_lvl[LVL_W*s +: LVL_W] == LVL_W'(lv));
        end
        assign req_lines[lv] = (|at_lvl) | stray[lv];
    end

    assert_single_taker_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));

    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
            clr[s] |=> !pend_q[s]);
        assert_pend_held_R7: assert property (@(posedge clk) disable iff (rst)
            (pend_q[s] && !clr[s]) |=> pend_q[s]);
    end

endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
    import irq_pkg::*;
#(
    parameter int VID_W = 6,
    parameter int TMO   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic [LVL_W-1:0] idx,
    input  logic             ack,
    input  logic [VID_W-1:0] ack_vid,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    output logic [NLVL-1:0]  grant,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    output logic             take,
    output handler_t         words,
    output logic             push_req,
    output logic             spurious
);
    localparam int CNT_W = (TMO > 1) ? $clog2(TMO) : 1;
    localparam int VEC_W = VID_W + 2;

    seq_state_e       state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [VEC_W-1:0] vec_q;
    handler_t         words_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            lvl_q   <= '0;
            cnt_q   <= '0;
            vec_q   <= '0;
            words_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    if (hit) begin
                        lvl_q   <= idx;
                        state_q <= S_GRANT;
                    end
                end
                S_GRANT: begin
                    if (ack) begin
                        vec_q   <= {ack_vid, 2'b00};
                        state_q <= S_RD_PC;
                    end else if (cnt_q == CNT_W'(TMO - 1)) begin
                        state_q <= S_SPUR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_RD_PC: begin
                    if (mem_ready) begin
                        words_q.pc <= mem_rdata;
                        state_q    <= S_RD_PSW;
                    end
                end
                S_RD_PSW: begin
                    if (mem_ready) begin
                        words_q.psw <= mem_rdata;
                        state_q     <= S_DELIVER;
                    end
                end
                S_DELIVER: state_q <= S_IDLE;
                S_SPUR:    state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        grant    = (state_q == S_GRANT) ? (NLVL'(1) << lvl_q) : '0;
        mem_rd   = (state_q == S_RD_PC) || (state_q == S_RD_PSW);
        mem_addr = AW'(vec_q) | ((state_q == S_RD_PSW) ? AW'(2) : AW'(0));
        take     = (state_q == S_DELIVER);
        words    = words_q;
        push_req = (state_q == S_RD_PC) || (state_q == S_RD_PSW) ||
                   (state_q == S_DELIVER);
        spurious = (state_q == S_SPUR);
    end

    assert_read_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
    assert_psw_offset_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd) && $past(mem_ready)) |->
            (mem_addr == $past(mem_addr) + AW'(2)));
    assert_spur_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        spurious |-> (!mem_rd && !push_req && !take));
    assert_take_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int VID_W = 6,
    parameter int TMO   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSLOT-1:0]       dev_raise,
    input  logic [NSLOT-1:0]       dev_clr,
    input  logic [2*NSLOT-1:0]     dev_level,
    input  logic [VID_W*NSLOT-1:0] dev_vid,
    input  logic [3:0]             stray_req,
    input  logic [2:0]             cur_pri,
    output logic [3:0]             grant_lines,
    output logic                   mem_rd,
    output logic [15:0]            mem_addr,
    input  logic                   mem_ready,
    input  logic [15:0]            mem_rdata,
    output logic                   irq_take,
    output logic [15:0]            new_pc,
    output logic [15:0]            new_psw,
    output logic                   push_req,
    output logic                   spurious
);
    logic [NLVL-1:0]  req_lines;
    logic             ack;
    logic [VID_W-1:0] ack_vid;
    logic             hit;
    logic [LVL_W-1:0] idx;
    handler_t         words;

    irq_slot_chain #(.NSLOT(NSLOT), .VID_W(VID_W)) chain_i (
        .clk       (clk),
        .rst       (rst),
        .raise     (dev_raise),
        .clr       (dev_clr),
        .slot_lvl  (dev_level),
        .slot_vid  (dev_vid),
        .stray     (stray_req),
        .grant     (grant_lines),
        .req_lines (req_lines),
        .ack       (ack),
        .ack_vid   (ack_vid)
    );

    irq_level_arb arb_i (
        .req_lines (req_lines),
        .cur_pri   (cur_pri),
        .hit       (hit),
        .idx       (idx)
    );

    irq_vec_seq #(.VID_W(VID_W), .TMO(TMO)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .idx       (idx),
        .ack       (ack),
        .ack_vid   (ack_vid),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .grant     (grant_lines),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .take      (irq_take),
        .words     (words),
        .push_req  (push_req),
        .spurious  (spurious)
    );

    assign new_pc  = words.pc;
    assign new_psw = words.psw;

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_lines));
    assert_grant_above_pri_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(|grant_lines) |->
            ((PRI_W'(LVL_BASE) + PRI_W'(grant_index(grant_lines))) > $past(cur_pri)));
    assert_push_before_take_R9: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> push_req);

endmodule

// File: tb/irq_chain_ctrl_tb_top.sv
module irq_chain_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;
    localparam int VID_W = 6;

    typedef struct {
        bit         spur;
        logic [7:0] vec;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSLOT-1:0]       dev_raise = '0;
    logic [NSLOT-1:0]       dev_clr = '0;
    logic [2*NSLOT-1:0]     dev_level = '0;
    logic [VID_W*NSLOT-1:0] dev_vid;
    logic [3:0]  stray_req = '0;
    logic [2:0]  cur_pri = '0;
    logic [3:0]  grant_lines;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        irq_take;
    logic [15:0] new_pc;
    logic [15:0] new_psw;
    logic        push_req;
    logic        spurious;

    int n_checks = 0;
    int n_fail = 0;
    int mem_delay = 0;
    int mem_cnt = 0;
    int g_run = 0;
    int g_last = 0;
    bit done = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_ctrl #(.NSLOT(NSLOT), .VID_W(VID_W), .TMO(16)) dut_i (
        .clk(clk), .rst(rst), .dev_raise(dev_raise), .dev_clr(dev_clr),
        .dev_level(dev_level), .dev_vid(dev_vid), .stray_req(stray_req),
        .cur_pri(cur_pri), .grant_lines(grant_lines), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .irq_take(irq_take), .new_pc(new_pc), .new_psw(new_psw),
        .push_req(push_req), .spurious(spurious)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        if (a[1]) return {a[7:0], 8'hE0};          // status word, priority 7
        return 16'h2000 | (a << 4);
    endfunction

    function automatic logic [7:0] vid_of(input int s);
        return 8'((10 + 5 * s) * 4);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (mem_rd) begin
            if (mem_cnt >= mem_delay) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                mem_cnt   <= 0;
            end else begin
                mem_ready <= 1'b0;
                mem_cnt   <= mem_cnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
            mem_cnt   <= 0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (grant_lines != 4'b0) g_run = g_run + 1;
            else if (g_run != 0) begin g_last = g_run; g_run = 0; end
            if (irq_take || spurious) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected event", {31'b0, spurious}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.spur) begin
                        check(spurious, "R8", "spurious outcome", {31'b0, spurious}, 1);
                        check(g_last == 16, "R8", "grant length", g_last, 16);
                        check(!push_req, "R9", "push on spurious", {31'b0, push_req}, 0);
                    end else begin
                        logic [15:0] va;
                        va = {8'h00, e.vec};
                        check(irq_take, "R4", "take outcome", {31'b0, irq_take}, 1);
                        check(new_pc == mem_word(va), "R5", "pc word", new_pc, mem_word(va));
                        check(new_psw == mem_word(va | 16'h2), "R6", "psw word",
                              new_psw, mem_word(va | 16'h2));
                        check(push_req, "R9", "push at take", {31'b0, push_req}, 1);
                    end
                end
            end
        end
    end

    task automatic raise_slots(input logic [NSLOT-1:0] m);
        @(negedge clk); dev_raise = m;
        @(negedge clk); dev_raise = '0;
    endtask

    task automatic clear_slot(input int s);
        @(negedge clk); dev_clr[s] = 1'b1;
        @(negedge clk); dev_clr[s] = 1'b0;
    endtask

    // wait for the next outcome; model the core loading the new priority
    task automatic wait_event();
        do @(negedge clk); while (!(irq_take || spurious));
        if (irq_take) cur_pri = new_psw[7:5];
    endtask

    task automatic serve(input int s, input logic [2:0] back_pri);
        exp_t e;
        e.spur = 0; e.vec = vid_of(s);
        exp_q.push_back(e);
        wait_event();
        clear_slot(s);
        @(negedge clk); cur_pri = back_pri;
    endtask

    task automatic quiet(input int n, input string req);
        bit seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (grant_lines != 0 || mem_rd || irq_take) seen = 1;
        end
        check(!seen, req, "no activity expected", {31'b0, seen}, 0);
    endtask

    initial begin
        for (int s = 0; s < NSLOT; s++) dev_vid[VID_W*s +: VID_W] = VID_W'(10 + 5 * s);
        repeat (3) @(negedge clk);
        check(grant_lines == 0 && !mem_rd && !irq_take && !push_req && !spurious,
              "R1", "outputs in reset", {27'b0, grant_lines, mem_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(grant_lines == 0 && !mem_rd && !push_req, "R1", "after reset",
              {27'b0, grant_lines, mem_rd}, 0);

        // R5/R6: single slot, level line 1, no memory wait
        dev_level[2*3 +: 2] = 2'd1;
        raise_slots(8'h08);
        serve(3, 3'd0);

        // R2/R7: two levels at once, higher first, lower later; slow memory
        mem_delay = 2;
        dev_level[2*5 +: 2] = 2'd1;
        dev_level[2*6 +: 2] = 2'd3;
        raise_slots(8'h60);
        serve(6, 3'd0);
        serve(5, 3'd0);

        // R4: same level, nearest slot first
        mem_delay = 1;
        dev_level[2*2 +: 2] = 2'd2;
        dev_level[2*4 +: 2] = 2'd2;
        raise_slots(8'h14);
        serve(2, 3'd0);
        serve(4, 3'd0);

        // R3: blocked at equal priority, served once priority drops
        mem_delay = 0;
        dev_level[2*1 +: 2] = 2'd1;
        cur_pri = 3'd5;
        raise_slots(8'h02);
        quiet(40, "R3");
        cur_pri = 3'd4;
        serve(1, 3'd0);

        // R8: stray request with nobody on that level
        begin
            exp_t e;
            e.spur = 1; e.vec = 0;
            exp_q.push_back(e);
            @(negedge clk); stray_req = 4'b0100;
            wait_event();
            stray_req = 4'b0000;
            @(negedge clk);
            check(!mem_rd && grant_lines == 0, "R8", "idle after spurious",
                  {27'b0, grant_lines, mem_rd}, 0);
        end

        // R10: clear and raise together leave slot idle
        dev_level[2*7 +: 2] = 2'd0;
        @(negedge clk); dev_raise[7] = 1'b1; dev_clr[7] = 1'b1;
        @(negedge clk); dev_raise[7] = 1'b0; dev_clr[7] = 1'b0;
        quiet(30, "R10");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7", "outstanding expected events", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule